// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block guards a multiport repeater against ports that misbehave on collisions. It keeps one small state machine and its counters for each port, and all of it advances only on a shared bit-time strobe. A port is isolated in two cases. The first is a collision (SQE) indication that stays asserted for more than a set number of bit times. The second is a run of consecutive transmit attempts to that port that all collide. An isolated port still gets the repeater's outgoing traffic, because this block never touches the transmit path. Its receive activity, however, is hidden from the repeater core, so it can no longer start a repeat.

An isolated port is reconnected once it has carried a long enough transmission without a collision. Each port is judged independently. A disabled port is never judged, and disabling it wipes all of its history. The repeater core uses the gated receive-activity outputs instead of the raw ones, and it can read the per-port isolation flags.

Top module: `port_partition_ctrl`

## Requirements
- R1: With a port enabled and the strobe pulsing, the port's partitioned flag rises after its collision input has been high on 2049 consecutive strobes. After 2048 such strobes the flag is still low.
- R2: A port becomes partitioned when 32 transmit attempts in a row end with a collision. After 31 such attempts it is still connected. An attempt is a run of strobes with txActive high. It ends on the first strobe that sees txActive low. It counts as colliding if collision was high on any strobe during the run.
- R3: A transmit attempt that ends without a collision sets the consecutive-collision count back to zero. A later partition then needs 32 fresh colliding attempts.
- R4: rxGated[i] equals rxActive[i] only when port i is enabled and not partitioned. Otherwise it is 0. It follows rxActive within the same cycle, with no register in the path.
- R5: A partitioned port reconnects when all of these hold: its collision input has gone low, and it then completes a transmit attempt of at least 512 strobes with no collision. An attempt of 511 strobes, or one that collides, leaves it partitioned.
- R6: While portEnable[i] is low, port i never partitions. On the first strobe with portEnable[i] low, its partition state and both of its counters are cleared.
- R7: Partitioning and reconnection of one port leave every other port's flag unchanged.
- R8: No state or counter changes on a clock edge where bitTick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle strobe per bit time; qualifies all updates |
| portEnable | input | NUM_PORTS | Per-port enable |
| txActive | input | NUM_PORTS | Repeater is transmitting to the port |
| rxActive | input | NUM_PORTS | Port reports receive activity |
| collision | input | NUM_PORTS | Port collision / SQE indication |
| partitioned | output | NUM_PORTS | Port is isolated from the repeater core |
| rxGated | output | NUM_PORTS | Receive activity passed on to the repeater core |

## Verification
The assertions assume a few things about the inputs. txActive and collision only carry meaning on strobe cycles. A transmit attempt is marked by txActive falling, as seen on a strobe. Any change of state has to be explained by a trip, a clean long attempt or a disable in the cycle before. The stimulus changes inputs only on falling clock edges. It keeps the strobe high on every cycle except in one deliberate window where it is held low. It also leaves idle strobes between attempts, so that every attempt end is observed.

// File: rtl/partition_pkg.sv
package partition_pkg;

  typedef enum logic [1:0] {
    PS_CONNECTED   = 2'd0,
    PS_PARTITIONED = 2'd1,
    PS_WATCHING    = 2'd2
  } partState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic clearStreak;
  } ctrlStrobe_t;

  // events reported by the datapath, already qualified by the bit strobe
  typedef struct packed {
    logic sqeTrip;
    logic streakTrip;
    logic cleanLongEnd;
    logic attemptEnd;
  } dpStatus_t;

endpackage

// File: rtl/part_datapath.sv
module part_datapath
  import partition_pkg::*;
#(
  parameter int SQE_LIMIT     = 2048,
  parameter int ATTEMPT_LIMIT = 32,
  parameter int RECON_LEN     = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        txActive,
  input  logic        collision,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int SQE_W    = $clog2(SQE_LIMIT + 1);
  localparam int STREAK_W = $clog2(ATTEMPT_LIMIT);
  localparam int LEN_W    = $clog2(RECON_LEN + 1);
  localparam logic [SQE_W-1:0]    SQE_MAX    = SQE_W'(SQE_LIMIT);
  localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(ATTEMPT_LIMIT - 1);
  localparam logic [LEN_W-1:0]    LEN_MAX    = LEN_W'(RECON_LEN);

  logic                txPrev;
  logic                attemptColl;
  logic [SQE_W-1:0]    sqeCnt;
  logic [STREAK_W-1:0] collStreak;
  logic [LEN_W-1:0]    txLen;
  logic                attemptStart;
  logic                attemptEnd;

  assign attemptStart = txActive & ~txPrev;
  assign attemptEnd   = ~txActive & txPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev      <= 1'b0;
      attemptColl <= 1'b0;
      sqeCnt      <= '0;
      collStreak  <= '0;
      txLen       <= '0;
    end else if (bitTick) begin
      txPrev <= txActive;
      if (strobe.clearAll) begin
        attemptColl <= 1'b0;
        sqeCnt      <= '0;
        collStreak  <= '0;
        txLen       <= '0;
      end else begin
        // continuous SQE duration
        if (!collision)            sqeCnt <= '0;
        else if (sqeCnt < SQE_MAX) sqeCnt <= sqeCnt + 1'b1;
        // per-attempt bookkeeping
        if (attemptStart) begin
          attemptColl <= collision;
          txLen       <= LEN_W'(1);
        end else if (txActive) begin
          attemptColl <= attemptColl | collision;
          if (txLen < LEN_MAX) txLen <= txLen + 1'b1;
        end
        // consecutive colliding attempts
        if (strobe.clearStreak)   collStreak <= '0;
        else if (attemptEnd) begin
          if (!attemptColl)                  collStreak <= '0;
          else if (collStreak != STREAK_MAX) collStreak <= collStreak + 1'b1;
        end
      end
    end
  end

  always_comb begin
    status.sqeTrip      = bitTick & collision & (sqeCnt >= SQE_MAX);
    status.streakTrip   = bitTick & attemptEnd & attemptColl & (collStreak == STREAK_MAX);
    status.cleanLongEnd = bitTick & attemptEnd & ~attemptColl & (txLen >= LEN_MAX);
    status.attemptEnd   = bitTick & attemptEnd;
  end

  assert_streak_clean_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && attemptEnd && !attemptColl) |=> (collStreak == '0));

  assert_sqe_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !collision) |=> (sqeCnt == '0));

  assert_counters_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> ($stable(sqeCnt) && $stable(collStreak) && $stable(txLen)));

endmodule

// File: rtl/part_ctrl.sv
module part_ctrl
  import partition_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        portEnable,
  input  logic        collision,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        partFlag
);

  partState_t state;
  partState_t stateNext;

  always_comb begin
    stateNext = state;
    if (!portEnable) begin
      stateNext = PS_CONNECTED;
    end else begin
      unique case (state)
        PS_CONNECTED:
          if (status.sqeTrip || status.streakTrip) stateNext = PS_PARTITIONED;
        PS_PARTITIONED:
          if (!collision) stateNext = PS_WATCHING;
        PS_WATCHING:
          if (collision)                stateNext = PS_PARTITIONED;
          else if (status.cleanLongEnd) stateNext = PS_CONNECTED;
        default: stateNext = PS_CONNECTED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= PS_CONNECTED;
    else if (bitTick) state <= stateNext;
  end

  always_comb begin
    strobe.clearAll    = ~portEnable;
    strobe.clearStreak = (state != PS_CONNECTED);
  end

  assign partFlag = (state != PS_CONNECTED);

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !portEnable) |=> !partFlag);

  assert_enter_has_trip_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(partFlag) |-> $past(status.sqeTrip || status.streakTrip));

  assert_leave_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(partFlag) |-> $past(status.cleanLongEnd || !portEnable));

  assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(state));

endmodule

// File: rtl/port_partition_ctrl.sv
module port_partition_ctrl
  import partition_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int SQE_LIMIT     = 2048,
  parameter int ATTEMPT_LIMIT = 32,
  parameter int RECON_LEN     = 512
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] txActive,
  input  logic [NUM_PORTS-1:0] rxActive,
  input  logic [NUM_PORTS-1:0] collision,
  output logic [NUM_PORTS-1:0] partitioned,
  output logic [NUM_PORTS-1:0] rxGated
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    ctrlStrobe_t strobe;
    dpStatus_t   status;
    logic        partFlag;

    part_datapath #(
      .SQE_LIMIT    (SQE_LIMIT),
      .ATTEMPT_LIMIT(ATTEMPT_LIMIT),
      .RECON_LEN    (RECON_LEN)
    ) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .bitTick  (bitTick),
      .txActive (txActive[i]),
      .collision(collision[i]),
      .strobe   (strobe),
      .status   (status)
    );

    part_ctrl u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .bitTick   (bitTick),
      .portEnable(portEnable[i]),
      .collision (collision[i]),
      .status    (status),
      .strobe    (strobe),
      .partFlag  (partFlag)
    );

    assign partitioned[i] = partFlag;
    assign rxGated[i]     = rxActive[i] & portEnable[i] & ~partFlag;

    assert_rx_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
      partitioned[i] |-> !rxGated[i]);
  end

endmodule

// File: tb/port_partition_ctrl_test.sv
`timescale 1ns/1ps
module port_partition_ctrl_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitTick = 1'b1;
  logic [N-1:0] portEnable = '0;
  logic [N-1:0] txActive = '0;
  logic [N-1:0] rxActive = '0;
  logic [N-1:0] collision = '0;
  logic [N-1:0] partitioned;
  logic [N-1:0] rxGated;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  port_partition_ctrl #(.NUM_PORTS(N)) uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .portEnable(portEnable),
    .txActive(txActive), .rxActive(rxActive), .collision(collision),
    .partitioned(partitioned), .rxGated(rxGated)
  );

  // {enable, rxActive, expected rxGated} with all ports connected
  localparam logic [11:0] GATE_VEC [0:5] = '{
    12'hFFF, 12'hF00, 12'h5F5, 12'hFAA, 12'h0F0, 12'hC64
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one transmit attempt of len strobes, then two idle strobes
  task automatic attempt(input int p, input int len, input logic coll);
    txActive[p]  = 1'b1;
    collision[p] = coll;
    waitTicks(len);
    txActive[p]  = 1'b0;
    collision[p] = 1'b0;
    waitTicks(2);
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitTicks(3);
    check("R4 reset partitioned", partitioned, 4'b0000);
    check("R4 reset rxGated", rxGated, 4'b0000);
    rstN = 1'b1;
    waitTicks(2);

    // R4: gating table, all ports connected
    foreach (GATE_VEC[k]) begin
      portEnable = GATE_VEC[k][11:8];
      rxActive   = GATE_VEC[k][7:4];
      #1;
      check("R4 gate table", rxGated, GATE_VEC[k][3:0]);
      @(negedge clk);
    end
    portEnable = 4'hF;
    rxActive   = 4'h0;
    waitTicks(2);

    // R1: SQE duration on port 0
    collision[0] = 1'b1;
    waitTicks(2048);
    check("R1 2048 strobes", partitioned, 4'b0000);
    waitTicks(1);
    check("R1 2049 strobes / R7", partitioned, 4'b0001);
    collision[0] = 1'b0;
    waitTicks(2);

    // R4: partitioned port is masked
    rxActive = 4'hF;
    #1;
    check("R4 masked while partitioned", rxGated, 4'b1110);
    rxActive = 4'h0;

    // R5: reconnection rules on port 0
    attempt(0, 600, 1'b1);
    check("R5 colliding long attempt", partitioned, 4'b0001);
    attempt(0, 511, 1'b0);
    check("R5 511 strobes", partitioned, 4'b0000 | 4'b0001);
    attempt(0, 512, 1'b0);
    check("R5 512 strobes reconnect", partitioned, 4'b0000);

    // R2 / R3 on port 2
    repeat (31) attempt(2, 4, 1'b1);
    check("R2 31 attempts", partitioned, 4'b0000);
    attempt(2, 4, 1'b0);
    repeat (31) attempt(2, 4, 1'b1);
    check("R3 streak reset by clean attempt", partitioned, 4'b0000);
    attempt(2, 4, 1'b1);
    check("R2 32 attempts / R7", partitioned, 4'b0100);

    // R6: disable clears counters on port 1
    repeat (31) attempt(1, 4, 1'b1);
    portEnable[1] = 1'b0;
    waitTicks(2);
    portEnable[1] = 1'b1;
    waitTicks(2);
    repeat (31) attempt(1, 4, 1'b1);
    check("R6 streak cleared by disable", partitioned, 4'b0100);
    attempt(1, 4, 1'b1);
    check("R6 fresh 32 attempts", partitioned, 4'b0110);
    portEnable[1] = 1'b0;
    waitTicks(2);
    check("R6 disable clears partition", partitioned, 4'b0100);
    collision[1] = 1'b1;
    waitTicks(2100);
    check("R6 disabled port not evaluated", partitioned, 4'b0100);
    collision[1] = 1'b0;
    portEnable[1] = 1'b1;
    waitTicks(2);

    // R8: nothing moves without the strobe
    bitTick = 1'b0;
    collision[3] = 1'b1;
    waitTicks(3000);
    check("R8 SQE without strobe", partitioned, 4'b0100);
    attempt(2, 600, 1'b0);
    check("R8 attempt without strobe", partitioned, 4'b0100);
    collision[3] = 1'b0;
    waitTicks(1);
    bitTick = 1'b1;
    waitTicks(3);
    check("R8 after strobe resumes", partitioned, 4'b0100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule